// File: doc/BRIEF.md
# Dual-Issue Slot Packer

This block sits between an in-order decode stage and a two-lane issue stage. It takes decoded instruction descriptors one at a time over a valid/ready stream and groups them into issue packets of two typed slots. Slot A takes an ALU or branch operation and slot B takes a load or store. A slot with nothing suitable to carry goes out as a no-op, which is a slot valid bit of zero.

Pairing follows program order. An instruction waits in a one-entry hold register. When the output can take a packet, the held instruction is paired with the instruction on the input in that cycle if three things are true: the held one is an ALU operation, the incoming one is a load or store, and the memory operation neither reads nor overwrites the register that the ALU operation writes. Otherwise the held instruction leaves alone and the incoming one takes its place in the hold register. If no input is offered, the held instruction is issued alone.

The control is a two-state machine. The state names and transitions are:
- EMPTY to HELD, on an accepted input.
- HELD to HELD, when a solo issue happens and a new input is accepted into the hold register in the same cycle.
- HELD to EMPTY, on a paired issue.
- HELD to EMPTY, on a solo issue with no input offered.
- HELD stays put while the output is stalled.

Top module: `dual_issue_packer`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: An ALU descriptor (class 2'b00) directly followed by an independent load (2'b10) or store (2'b11) leaves as one packet, with the ALU in slot A and the memory operation in slot B, both slot valid bits set. The descriptor layout is: class in bits [1:0], rd in [6:2], rs1 in [11:7], rs2 in [16:12], tag in [24:17]. Bit 1 of the class marks a memory operation.
- R3: A packet never has both slot valid bits clear. A valid slot A always holds class 2'b00 or 2'b01. A valid slot B always holds class 2'b10 or 2'b11. An instruction issued alone uses the slot of its own type, and the other slot has its valid bit at 0.
- R4: A branch (class 2'b01) is always issued with slot B empty, even when a load or store follows it.
- R5: A memory operation whose rs1, or for a store whose rs2, equals the rd of the preceding ALU operation is not paired with it. It is issued in a later packet. A load's rs2 field is ignored for this test.
- R6: A load whose rd equals the rd of the preceding ALU operation is not paired with it.
- R7: Two ALU operations in a row, or a memory operation at the head, produce solo packets. Program order is kept and every instruction appears exactly once.
- R8: While out_valid is 1 and out_ready is 0, the packet stays unchanged and in_ready is 0.
- R9: A descriptor accepted at clock edge k, with no following input and a free output, appears as a solo packet after edge k+1 and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Descriptor offered |
| in_ready | output | 1 | Descriptor accepted this cycle when in_valid is also 1 |
| in_desc | input | 25 | Decoded instruction descriptor |
| out_valid | output | 1 | Packet present |
| out_ready | input | 1 | Downstream takes the packet |
| out_a_valid | output | 1 | Slot A occupied (0 = no-op) |
| out_a_desc | output | 25 | Slot A descriptor (ALU or branch) |
| out_b_valid | output | 1 | Slot B occupied (0 = no-op) |
| out_b_desc | output | 25 | Slot B descriptor (load or store) |

## Verification
A corrupted hold register shows up at the ports within two clocks. It appears as a duplicated, missing or reordered tag in the next packet, and the scoreboard catches that because it compares each packet against an order-based model. A wrong pairing decision puts a dependent or mistyped pair on the output in the same cycle the packet loads. A wrong stall path shows up as a packet that changes, or an input that is taken, while out_ready is low. The stall checks are made on every cycle of that condition.

// File: rtl/pack_pkg.sv
package pack_pkg;

    parameter int unsigned REG_W = 5;
    parameter int unsigned TAG_W = 8;
    parameter int unsigned NSLOT = 2;

    typedef enum logic [1:0] {
        CLS_ALU    = 2'b00,
        CLS_BRANCH = 2'b01,
        CLS_LOAD   = 2'b10,
        CLS_STORE  = 2'b11
    } op_class_e;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [REG_W-1:0] rs2;
        logic [REG_W-1:0] rs1;
        logic [REG_W-1:0] rd;
        op_class_e        cls;
    } insn_t;

    localparam int unsigned INSN_W = $bits(insn_t);
    localparam int unsigned SLOT_A = 0;
    localparam int unsigned SLOT_B = 1;

endpackage

// File: rtl/pack_pair_rule.sv
module pack_pair_rule
    import pack_pkg::*;
(
    input  op_class_e        head_cls,
    input  logic [REG_W-1:0] head_rd,
    input  op_class_e        nxt_cls,
    input  logic [REG_W-1:0] nxt_rd,
    input  logic [REG_W-1:0] nxt_rs1,
    input  logic [REG_W-1:0] nxt_rs2,
    output logic             pair_ok
);
    localparam int unsigned NSRC = 2;

    logic [REG_W-1:0] src_reg [NSRC];
    logic [NSRC-1:0]  src_used;
    logic [NSRC-1:0]  src_hit;
    logic             head_alu;
    logic             nxt_mem;
    logic             raw_hit;
    logic             waw_hit;

    assign src_reg[0]  = nxt_rs1;
    assign src_reg[1]  = nxt_rs2;
    assign src_used[0] = 1'b1;
    assign src_used[1] = (nxt_cls == CLS_STORE);

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign src_hit[g] = src_used[g] && (src_reg[g] == head_rd);
    end

    assign head_alu = (head_cls == CLS_ALU);
    assign nxt_mem  = (nxt_cls == CLS_LOAD) || (nxt_cls == CLS_STORE);
    assign raw_hit  = head_alu && (|src_hit);
    assign waw_hit  = head_alu && (nxt_cls == CLS_LOAD) && (nxt_rd == head_rd);
    assign pair_ok  = head_alu && nxt_mem && !raw_hit && !waw_hit;

endmodule

// File: rtl/pack_out_reg.sv
module pack_out_reg #(
    parameter int unsigned W     = 8,
    parameter int unsigned SLOTS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             fill_i,
    input  logic [SLOTS-1:0] v_i,
    input  logic [W-1:0]     d_i [SLOTS],
    output logic             pkt_valid_o,
    output logic [SLOTS-1:0] v_o,
    output logic [W-1:0]     d_o [SLOTS]
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pkt_valid_o <= 1'b0;
        end else if (load_i) begin
            pkt_valid_o <= fill_i;
        end
    end

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_o[g] <= 1'b0;
                d_o[g] <= '0;
            end else if (load_i) begin
                v_o[g] <= fill_i & v_i[g];
                if (fill_i) begin
                    d_o[g] <= d_i[g];
                end
            end
        end
    end

    // A packet on the output always carries at least one real slot
    assert_slot_present_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid_o |-> (|v_o));

endmodule

// File: rtl/dual_issue_packer.sv
module dual_issue_packer
    import pack_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [INSN_W-1:0] in_desc,
    output logic              out_valid,
    input  logic              out_ready,
    output logic              out_a_valid,
    output logic [INSN_W-1:0] out_a_desc,
    output logic              out_b_valid,
    output logic [INSN_W-1:0] out_b_desc
);
    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_HELD  = 1'b1
    } fill_state_e;

    fill_state_e state_q, state_d;
    insn_t       held_q, held_d;
    insn_t       in_insn;
    logic        pair_ok;
    logic        out_load;
    logic        out_fill;
    logic [NSLOT-1:0]  slot_v;
    logic [INSN_W-1:0] slot_d [NSLOT];
    logic [NSLOT-1:0]  reg_v;
    logic [INSN_W-1:0] reg_d [NSLOT];

    assign in_insn = insn_t'(in_desc);

    pack_pair_rule u_rule (
        .head_cls (held_q.cls),
        .head_rd  (held_q.rd),
        .nxt_cls  (in_insn.cls),
        .nxt_rd   (in_insn.rd),
        .nxt_rs1  (in_insn.rs1),
        .nxt_rs2  (in_insn.rs2),
        .pair_ok  (pair_ok)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            held_q  <= '0;
        end else begin
            state_q <= state_d;
            held_q  <= held_d;
        end
    end

    // Next state and packet formation
    always_comb begin
        out_load        = !out_valid || out_ready;
        in_ready        = out_load;
        state_d         = state_q;
        held_d          = held_q;
        out_fill        = 1'b0;
        slot_v          = '0;
        slot_d[SLOT_A]  = held_q;
        slot_d[SLOT_B]  = held_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (in_valid && out_load) begin
                    state_d = ST_HELD;
                    held_d  = in_insn;
                end
            end
            ST_HELD: begin
                if (out_load) begin
                    out_fill = 1'b1;
                    if (in_valid && pair_ok) begin
                        slot_v         = '1;
                        slot_d[SLOT_B] = in_insn;
                        state_d        = ST_EMPTY;
                    end else begin
                        if (held_q.cls[1]) begin
                            slot_v[SLOT_B] = 1'b1;
                        end else begin
                            slot_v[SLOT_A] = 1'b1;
                        end
                        if (in_valid) begin
                            held_d = in_insn;
                        end else begin
                            state_d = ST_EMPTY;
                        end
                    end
                end
            end
        endcase
    end

    pack_out_reg #(.W(INSN_W), .SLOTS(NSLOT)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (out_load),
        .fill_i      (out_fill),
        .v_i         (slot_v),
        .d_i         (slot_d),
        .pkt_valid_o (out_valid),
        .v_o         (reg_v),
        .d_o         (reg_d)
    );

    assign out_a_valid = reg_v[SLOT_A];
    assign out_b_valid = reg_v[SLOT_B];
    assign out_a_desc  = reg_d[SLOT_A];
    assign out_b_desc  = reg_d[SLOT_B];

    // Output-side views for the checks below
    insn_t pa, pb;
    assign pa = insn_t'(out_a_desc);
    assign pb = insn_t'(out_b_desc);

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_a_valid) && $stable(out_b_valid)
                                       && $stable(out_a_desc) && $stable(out_b_desc)));

    assert_stall_no_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    assert_slot_a_type_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_a_valid) |-> !pa.cls[1]);

    assert_slot_b_type_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_b_valid) |-> pb.cls[1]);

    assert_branch_alone_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_a_valid && pa.cls == CLS_BRANCH) |-> !out_b_valid);

    assert_no_raw_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_a_valid && out_b_valid) |->
            (pb.rs1 != pa.rd) && !(pb.cls == CLS_STORE && pb.rs2 == pa.rd));

    assert_no_waw_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_a_valid && out_b_valid && pb.cls == CLS_LOAD) |-> (pb.rd != pa.rd));

endmodule

// File: tb/dual_issue_packer_tb_top.sv
module dual_issue_packer_tb_top;
    import pack_pkg::*;
    localparam int DW = INSN_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [DW-1:0] in_desc = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic          out_a_valid, out_b_valid;
    logic [DW-1:0] out_a_desc, out_b_desc;

    dual_issue_packer dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_desc(in_desc),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_a_valid(out_a_valid), .out_a_desc(out_a_desc),
        .out_b_valid(out_b_valid), .out_b_desc(out_b_desc)
    );

    typedef struct {
        logic          av;
        logic [DW-1:0] a;
        logic          bv;
        logic [DW-1:0] b;
        string         req;
    } exp_t;

    int            checks = 0;
    int            fails  = 0;
    bit            stall_en = 1'b0;
    bit            done = 1'b0;
    int unsigned   cyc = 0;
    exp_t          exp_q[$];
    logic [DW-1:0] grp[$];
    logic [TAG_W-1:0] next_tag = 1;

    function automatic logic [DW-1:0] mk(input logic [1:0] c, input int rd, input int rs1,
                                         input int rs2, input logic [TAG_W-1:0] t);
        return {t, rs2[REG_W-1:0], rs1[REG_W-1:0], rd[REG_W-1:0], c};
    endfunction

    function automatic logic [REG_W-1:0] f_rd(input logic [DW-1:0] d);
        return d[2 +: REG_W];
    endfunction
    function automatic logic [REG_W-1:0] f_rs1(input logic [DW-1:0] d);
        return d[2+REG_W +: REG_W];
    endfunction
    function automatic logic [REG_W-1:0] f_rs2(input logic [DW-1:0] d);
        return d[2+2*REG_W +: REG_W];
    endfunction

    // Pairing rule taken from R2, R4, R5, R6, R7
    function automatic bit can_pair(input logic [DW-1:0] h, input logic [DW-1:0] n);
        if (h[1:0] != 2'b00) return 1'b0;
        if (n[1] != 1'b1) return 1'b0;
        if (f_rs1(n) == f_rd(h)) return 1'b0;
        if (n[1:0] == 2'b11 && f_rs2(n) == f_rd(h)) return 1'b0;
        if (n[1:0] == 2'b10 && f_rd(n) == f_rd(h)) return 1'b0;
        return 1'b1;
    endfunction

    task automatic add(input logic [1:0] c, input int rd, input int rs1, input int rs2);
        grp.push_back(mk(c, rd, rs1, rs2, next_tag));
        next_tag++;
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model(input string req);
        int i = 0;
        exp_t e;
        while (i < grp.size()) begin
            e.req = req;
            e.a = '0; e.b = '0; e.av = 1'b0; e.bv = 1'b0;
            if (i + 1 < grp.size() && can_pair(grp[i], grp[i+1])) begin
                e.av = 1'b1; e.a = grp[i]; e.bv = 1'b1; e.b = grp[i+1];
                i += 2;
            end else begin
                if (grp[i][1]) begin e.bv = 1'b1; e.b = grp[i]; end
                else           begin e.av = 1'b1; e.a = grp[i]; end
                i += 1;
            end
            exp_q.push_back(e);
        end
    endtask

    task automatic drive_group(input string req);
        model(req);
        foreach (grp[k]) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_desc  = grp[k];
            #1;
            while (!in_ready) begin
                @(negedge clk);
                #1;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        grp.delete();
        repeat (6) @(negedge clk);
    endtask

    // Output stall pattern
    always @(negedge clk) begin
        cyc++;
        out_ready <= stall_en ? ((cyc % 3) != 0) : 1'b1;
    end

    // Monitor / scoreboard
    bit            was_stall = 1'b0;
    logic          s_av, s_bv;
    logic [DW-1:0] s_a, s_b;
    always begin
        @(negedge clk);
        #2;
        if (rst_n) begin
            if (was_stall) begin
                check(out_valid && out_a_valid == s_av && out_b_valid == s_bv &&
                      out_a_desc == s_a && out_b_desc == s_b,
                      "R8", "packet changed under stall", out_a_desc, s_a);
            end
            was_stall = out_valid && !out_ready;
            if (was_stall) begin
                s_av = out_a_valid; s_bv = out_b_valid; s_a = out_a_desc; s_b = out_b_desc;
                check(!in_ready, "R8", "in_ready high under stall", DW'(in_ready), '0);
            end
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7", "unexpected packet", out_a_desc, '0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(out_a_valid == e.av && (!e.av || out_a_desc == e.a),
                          e.req, "slot A", {out_a_valid, out_a_desc[DW-2:0]}, {e.av, e.a[DW-2:0]});
                    check(out_b_valid == e.bv && (!e.bv || out_b_desc == e.b),
                          e.req, "slot B", {out_b_valid, out_b_desc[DW-2:0]}, {e.bv, e.b[DW-2:0]});
                end
            end
        end
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog actual=%0d expected=<20000 cycles", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(!out_valid, "R1", "out_valid after reset", DW'(out_valid), '0);
        check(in_ready, "R1", "in_ready after reset", DW'(in_ready), DW'(1));

        // R9: latency of a lone descriptor
        begin
            exp_t e;
            logic [DW-1:0] d;
            d = mk(2'b00, 3, 1, 2, next_tag);
            next_tag++;
            e.av = 1'b1; e.a = d; e.bv = 1'b0; e.b = '0; e.req = "R9";
            exp_q.push_back(e);
            @(negedge clk);
            in_valid = 1'b1;
            in_desc  = d;
            #1;
            check(in_ready, "R9", "input not accepted", DW'(in_ready), DW'(1));
            @(negedge clk);
            in_valid = 1'b0;
            #1;
            check(!out_valid, "R9", "packet too early", DW'(out_valid), '0);
            @(negedge clk);
            #1;
            check(out_valid && out_a_valid && !out_b_valid, "R9", "solo packet missing",
                  DW'({out_valid, out_a_valid, out_b_valid}), DW'(3'b110));
            repeat (4) @(negedge clk);
        end

        // R2: independent ALU + load, ALU + store
        add(2'b00, 3, 1, 2);  add(2'b10, 4, 5, 0);
        add(2'b00, 6, 1, 2);  add(2'b11, 0, 7, 9);
        drive_group("R2");

        // R3 and R7: ALU, ALU, store; load head then ALU; store head
        add(2'b00, 8, 1, 2);  add(2'b00, 9, 1, 2);  add(2'b11, 0, 10, 11);
        add(2'b10, 12, 1, 0); add(2'b00, 13, 1, 2);
        add(2'b11, 0, 1, 2);  add(2'b10, 14, 2, 0);
        drive_group("R3/R7");

        // R4: branch followed by memory operations
        add(2'b01, 0, 1, 2);  add(2'b10, 5, 6, 0);
        add(2'b01, 0, 3, 4);  add(2'b11, 0, 6, 7);
        drive_group("R4");

        // R5: read-after-write splits; a load's rs2 does not count
        add(2'b00, 7, 1, 2);  add(2'b10, 4, 7, 0);
        add(2'b00, 8, 1, 2);  add(2'b11, 0, 3, 8);
        add(2'b00, 8, 1, 2);  add(2'b10, 9, 3, 8);
        add(2'b00, 10, 1, 2); add(2'b11, 0, 10, 4);
        drive_group("R5");

        // R6: write-after-write splits; store rd does not count
        add(2'b00, 6, 1, 2);  add(2'b10, 6, 1, 0);
        add(2'b00, 11, 1, 2); add(2'b11, 11, 3, 4);
        drive_group("R6");

        // R8: mixed stream with output stalls
        stall_en = 1'b1;
        add(2'b00, 1, 2, 3);  add(2'b10, 4, 5, 0);
        add(2'b00, 6, 7, 8);  add(2'b00, 9, 6, 1);
        add(2'b11, 0, 9, 2);  add(2'b01, 0, 1, 2);
        add(2'b10, 3, 4, 0);  add(2'b00, 12, 1, 1);
        add(2'b11, 0, 4, 5);  add(2'b00, 15, 1, 2);
        add(2'b10, 15, 3, 0); add(2'b11, 0, 2, 3);
        drive_group("R8");
        stall_en = 1'b0;

        while (exp_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        check(!out_valid, "R7", "extra packet after drain", DW'(out_valid), '0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule